// File: doc/BRIEF.md
# Branch Condition and Next-PC Unit

This combinational unit works out where a 64-bit register machine fetches from next. Each cycle it receives the current program counter, the 8-bit opcode, a signed 16-bit branch displacement, the two operand values and the 32-bit immediate. The program counter counts 8-byte instruction slots. The outputs are the next program counter, a taken flag, call and exit indications, and an illegal-instruction flag.

Two jump classes share one set of comparators. One class compares full 64-bit operands. The other class compares only the low 32 bits of each operand. There are unsigned and signed magnitude compares, equality tests and a bit-test.

The one instruction that fills two slots is the wide-immediate load. For that instruction the unit advances the program counter by two. All other non-jump instructions advance it by one. Executing calls, stack handling and register writeback are left to other blocks.

Top module: `branch_next_pc`

## Requirements
- R1: An opcode whose low three bits are neither 5 nor 6, other than 0x18, gives next_pc = pc + 1 with taken, call, exit and illegal all low.
- R2: Opcode 0x18 (wide-immediate load) gives next_pc = pc + 2 and taken low.
- R3: A taken branch gives next_pc = pc + 1 + the sign-extended 16-bit offset, modulo 2^PC_W.
- R4: A conditional jump whose condition is false gives next_pc = pc + 1 with taken low.
- R5: Opcode class 5 (opcode[2:0] = 5) compares the full 64-bit operands. Class 6 compares only bits 31:0 of each operand.
- R6: The unsigned compares use these values of opcode[7:4]: greater 0x2, greater-or-equal 0x3, less 0xa, less-or-equal 0xb.
- R7: The signed compares use these values of opcode[7:4]: greater 0x6, greater-or-equal 0x7, less 0xc, less-or-equal 0xd. In class 6 the sign is bit 31.
- R8: The remaining conditions use these values of opcode[7:4]: equal 0x1, not-equal 0x5, and bit-test 0x4. Bit-test is taken when the AND of the two operands is nonzero.
- R9: Opcode bit 3 set selects the source register as the second operand. When it is clear, the immediate sign-extended to 64 bits is used instead.
- R10: Code 0x0 in class 5 is an unconditional jump and is always taken.
- R11: Code 0x8 raises call, and code 0x9 in class 5 raises exit. Both give next_pc = pc + 1 with taken low.
- R12: Code 0x0 or 0x9 in class 6, and codes 0xe and 0xf in either jump class, raise illegal, leave next_pc = pc, and keep taken, call and exit low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pc_i | input | PC_W | Current program counter in 8-byte slots |
| opcode_i | input | 8 | Instruction opcode |
| offset_i | input | 16 | Signed branch displacement in slots |
| dst_i | input | XLEN | Destination-register operand |
| src_i | input | XLEN | Source-register operand |
| imm_i | input | 32 | Immediate field |
| next_pc_o | output | PC_W | Next program counter |
| taken_o | output | 1 | Branch taken |
| call_o | output | 1 | Call instruction seen |
| exit_o | output | 1 | Exit instruction seen |
| illegal_o | output | 1 | Undefined jump encoding |

## Verification
The embedded assertions check the relations between the program counter and the outputs every time the inputs change. These cover the target arithmetic of a taken branch, the unchanged counter on an illegal encoding, the two-slot step, the mutual exclusion of the flags, and the absence of a taken flag outside the jump classes. The assertions cannot show whether a given comparison should be true. The directed scenarios show this with chosen operand pairs: values that differ only above bit 31, values whose signed and unsigned orders disagree, sign-extended immediates, and operands at equality, where the strict and non-strict compares split.

// File: rtl/branch_next_pc.sv
module branch_next_pc #(
  parameter int PC_W = 32,
  parameter int XLEN = 64
) (
  input  logic [PC_W-1:0] pc_i,
  input  logic [7:0]      opcode_i,
  input  logic [15:0]     offset_i,
  input  logic [XLEN-1:0] dst_i,
  input  logic [XLEN-1:0] src_i,
  input  logic [31:0]     imm_i,
  output logic [PC_W-1:0] next_pc_o,
  output logic            taken_o,
  output logic            call_o,
  output logic            exit_o,
  output logic            illegal_o
);
  localparam int OFF_W = 16;
  localparam int IMM_W = 32;
  localparam int HALF  = 32;
  localparam logic [7:0] WIDE_LD = 8'h18;

  logic [2:0] cls;
  logic [3:0] code;
  logic       is64, is32, is_jmp, wide;
  assign cls    = opcode_i[2:0];
  assign code   = opcode_i[7:4];
  assign is64   = cls == 3'd5;
  assign is32   = cls == 3'd6;
  assign is_jmp = is64 | is32;
  assign wide   = opcode_i == WIDE_LD;

  logic [XLEN-1:0] opb;
  assign opb = opcode_i[3] ? src_i : {{(XLEN-IMM_W){imm_i[IMM_W-1]}}, imm_i};

  logic [HALF-1:0] a_lo, b_lo;
  assign a_lo = dst_i[HALF-1:0];
  assign b_lo = opb[HALF-1:0];

  logic eq, ltu, lts, bset;
  assign eq   = is32 ? (a_lo == b_lo) : (dst_i == opb);
  assign ltu  = is32 ? (a_lo < b_lo)  : (dst_i < opb);
  assign lts  = is32 ? ($signed(a_lo) < $signed(b_lo)) : ($signed(dst_i) < $signed(opb));
  assign bset = is32 ? (|(a_lo & b_lo)) : (|(dst_i & opb));

  logic cond, bad, is_call, is_exit;
  always_comb begin
    cond    = 1'b0;
    bad     = 1'b0;
    is_call = 1'b0;
    is_exit = 1'b0;
    unique case (code)
      4'h0: begin cond = is64; bad = is32; end
      4'h1: cond = eq;
      4'h2: cond = !ltu && !eq;
      4'h3: cond = !ltu;
      4'h4: cond = bset;
      4'h5: cond = !eq;
      4'h6: cond = !lts && !eq;
      4'h7: cond = !lts;
      4'h8: is_call = 1'b1;
      4'h9: begin is_exit = is64; bad = is32; end
      4'ha: cond = ltu;
      4'hb: cond = ltu || eq;
      4'hc: cond = lts;
      4'hd: cond = lts || eq;
      default: bad = 1'b1;
    endcase
  end

  logic [PC_W-1:0] off_ext, pc_p1, target;
  assign off_ext = {{(PC_W-OFF_W){offset_i[OFF_W-1]}}, offset_i};
  assign pc_p1   = pc_i + 1'b1;
  assign target  = pc_p1 + off_ext;

  assign illegal_o = is_jmp && bad;
  assign taken_o   = is_jmp && cond && !bad;
  assign call_o    = is_jmp && is_call;
  assign exit_o    = is_jmp && is_exit;

  always_comb begin
    if (illegal_o)    next_pc_o = pc_i;
    else if (taken_o) next_pc_o = target;
    else if (wide)    next_pc_o = pc_i + 2'd2;
    else              next_pc_o = pc_p1;
  end

  always_comb begin
    // R3
    if (taken_o) taken_target_chk: assert (next_pc_o - pc_i - 1'b1 == off_ext)
      else $error("taken target mismatch");
    // R12
    if (illegal_o) illegal_hold_chk: assert (next_pc_o == pc_i && !taken_o && !call_o && !exit_o)
      else $error("illegal encoding moved pc");
    // R2
    if (wide) wide_step_chk: assert (next_pc_o == pc_i + 2'd2 && !taken_o)
      else $error("wide load step wrong");
    // R1
    if (cls != 3'd5 && cls != 3'd6) nonjump_flags_chk: assert (!taken_o && !call_o && !exit_o && !illegal_o)
      else $error("flag outside jump class");
    // R11
    flags_excl_chk: assert ($onehot0({taken_o, call_o, exit_o, illegal_o}))
      else $error("flags not exclusive");
  end
endmodule

// File: tb/branch_next_pc_bench.sv
module branch_next_pc_bench;
  localparam int CLK_PERIOD = 10;
  localparam int PC_W = 32;
  localparam int XLEN = 64;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [PC_W-1:0] pc;
  logic [7:0]      op;
  logic [15:0]     off;
  logic [XLEN-1:0] dst, src;
  logic [31:0]     imm;
  logic [PC_W-1:0] next_pc;
  logic taken, call, ex, ill;
  int total = 0, bad = 0;
  bit done = 0;

  branch_next_pc #(.PC_W(PC_W), .XLEN(XLEN)) u_branch_next_pc (
    .pc_i(pc), .opcode_i(op), .offset_i(off), .dst_i(dst), .src_i(src), .imm_i(imm),
    .next_pc_o(next_pc), .taken_o(taken), .call_o(call), .exit_o(ex), .illegal_o(ill));

  task automatic drive(input logic [PC_W-1:0] p, input logic [7:0] o, input logic [15:0] f,
                       input logic [XLEN-1:0] d, input logic [XLEN-1:0] s, input logic [31:0] i);
    @(negedge clk);
    pc = p; op = o; off = f; dst = d; src = s; imm = i;
    #1;
  endtask

  task automatic chk(input string tag, input logic [PC_W-1:0] en, input logic et,
                     input logic ec, input logic ee, input logic ei);
    total++;
    if (next_pc !== en || taken !== et || call !== ec || ex !== ee || ill !== ei) begin
      bad++;
      $display("FAIL %s: got pc=%0h t=%b c=%b e=%b i=%b, exp pc=%0h t=%b c=%b e=%b i=%b",
               tag, next_pc, taken, call, ex, ill, en, et, ec, ee, ei);
    end
  endtask

  task automatic t_idle_and_plain; // R1
    drive(0, 8'h00, 0, 0, 0, 0);        chk("R1 idle", 1, 0, 0, 0, 0);
    drive(100, 8'h07, 16'h7, 5, 6, 7);  chk("R1 alu", 101, 0, 0, 0, 0);
    drive(100, 8'h61, 16'hfff0, 1, 1, 1); chk("R1 load", 101, 0, 0, 0, 0);
  endtask

  task automatic t_wide; // R2
    drive(100, 8'h18, 16'h10, 0, 0, 0); chk("R2 wide", 102, 0, 0, 0, 0);
  endtask

  task automatic t_offsets; // R3 R10
    drive(100, 8'h05, 16'hfffb, 0, 0, 0); chk("R10 ja back", 96, 1, 0, 0, 0);
    drive(0, 8'h05, 16'hfffd, 0, 0, 0);   chk("R3 wrap", 32'hffff_fffe, 1, 0, 0, 0);
    drive(10, 8'h05, 16'h7fff, 0, 0, 0);  chk("R3 max fwd", 10 + 1 + 32'h7fff, 1, 0, 0, 0);
  endtask

  task automatic t_width; // R5
    drive(100, 8'h1d, 8, 64'h1_0000_0005, 64'h2_0000_0005, 0); chk("R5 eq64 upper", 101, 0, 0, 0, 0);
    drive(100, 8'h1e, 8, 64'h1_0000_0005, 64'h2_0000_0005, 0); chk("R5 eq32 lower", 109, 1, 0, 0, 0);
  endtask

  task automatic t_unsigned; // R6 R4
    drive(100, 8'h2d, 4, '1, 1, 0); chk("R6 gt", 105, 1, 0, 0, 0);
    drive(100, 8'h3d, 4, 1, 2, 0);  chk("R6 ge false R4", 101, 0, 0, 0, 0);
    drive(100, 8'h3d, 4, 2, 2, 0);  chk("R6 ge equal", 105, 1, 0, 0, 0);
    drive(100, 8'had, 4, 1, 2, 0);  chk("R6 lt", 105, 1, 0, 0, 0);
    drive(100, 8'hbd, 4, 2, 2, 0);  chk("R6 le equal", 105, 1, 0, 0, 0);
    drive(100, 8'h2d, 4, 2, 2, 0);  chk("R6 gt equal", 101, 0, 0, 0, 0);
  endtask

  task automatic t_signed; // R7
    drive(100, 8'h6d, 4, '1, 1, 0); chk("R7 sgt neg", 101, 0, 0, 0, 0);
    drive(100, 8'hcd, 4, '1, 1, 0); chk("R7 slt neg", 105, 1, 0, 0, 0);
    drive(100, 8'h7d, 4, '1, '1, 0); chk("R7 sge equal", 105, 1, 0, 0, 0);
    drive(100, 8'hdd, 4, 2, 1, 0);  chk("R7 sle false", 101, 0, 0, 0, 0);
    drive(100, 8'h6e, 4, 64'h8000_0000, 1, 0); chk("R7 sgt32 sign", 101, 0, 0, 0, 0);
    drive(100, 8'h6d, 4, 64'h8000_0000, 1, 0); chk("R7 sgt64 pos", 105, 1, 0, 0, 0);
  endtask

  task automatic t_equality; // R8
    drive(100, 8'h4d, 4, 64'hf0, 64'h0f, 0); chk("R8 set zero", 101, 0, 0, 0, 0);
    drive(100, 8'h4d, 4, 64'hf0, 64'h10, 0); chk("R8 set hit", 105, 1, 0, 0, 0);
    drive(100, 8'h5d, 4, 3, 3, 0);          chk("R8 ne equal", 101, 0, 0, 0, 0);
    drive(100, 8'h5d, 4, 3, 4, 0);          chk("R8 ne differ", 105, 1, 0, 0, 0);
  endtask

  task automatic t_source; // R9
    drive(100, 8'h15, 4, '1, 0, 32'hffff_ffff); chk("R9 imm sext", 105, 1, 0, 0, 0);
    drive(100, 8'h25, 4, 5, 0, 32'hffff_ffff);  chk("R9 imm unsigned big", 101, 0, 0, 0, 0);
    drive(100, 8'h1d, 4, 7, 0, 7);              chk("R9 reg selected", 101, 0, 0, 0, 0);
  endtask

  task automatic t_call_exit; // R11
    drive(100, 8'h85, 4, 0, 0, 0); chk("R11 call", 101, 0, 1, 0, 0);
    drive(100, 8'h95, 4, 0, 0, 0); chk("R11 exit", 101, 0, 0, 1, 0);
  endtask

  task automatic t_illegal; // R12
    drive(100, 8'h06, 4, 0, 0, 0); chk("R12 ja32", 100, 0, 0, 0, 1);
    drive(100, 8'h96, 4, 0, 0, 0); chk("R12 exit32", 100, 0, 0, 0, 1);
    drive(100, 8'he5, 4, 0, 0, 0); chk("R12 code e", 100, 0, 0, 0, 1);
    drive(100, 8'hfe, 4, 0, 0, 0); chk("R12 code f", 100, 0, 0, 0, 1);
  endtask

  initial begin
    pc = 0; op = 0; off = 0; dst = 0; src = 0; imm = 0;
    repeat (2) @(posedge clk);
    t_idle_and_plain();
    t_wide();
    t_offsets();
    t_width();
    t_unsigned();
    t_signed();
    t_equality();
    t_source();
    t_call_exit();
    t_illegal();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: got timeout, exp completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule